// File: doc/BRIEF.md
# Lockout Stream ID Serial Sender

This block sits on the lock side of a cartridge authentication handshake and runs its start-up sequence. It divides a 4 MHz input clock into 1 µs machine-cycle ticks. A start strobe captures a 4-bit seed value from 0 to 15. On the same edge, the block asserts an active-high reset toward the partner key chip. That edge is time zero.

The four seed bits then go out on a single data line in the order 3, 0, 1, 2. The slots are 15 µs apart, and the first one is at 33 µs. A bit of value 1 shows up as a short high pulse, and a bit of value 0 leaves the line low. At 201 µs the block raises a flag for one tick to mark the start of the main exchange loop. It then returns to idle. Creating the seed and running the later bit exchange are done elsewhere.

Top module: `lock_seed_sender`

## Requirements
- R1: One timing tick equals CLK_PER_TICK input clocks (default 4). The tick count, in µs, after a start is the number of clock edges since the start edge divided by 4, rounded down.
- R2: A start strobe seen while idle does three things on that edge: it captures seed_i, raises busy_o, and raises key_rst_o.
- R3: key_rst_o is active high. It stays high for exactly KEY_RST_TICKS ticks (default 2) from time zero and is low at all other times.
- R4: dout_o is low from time zero until the first slot begins at 33 µs.
- R5: The slots start at 33, 48, 63 and 78 µs and carry seed bits 3, 0, 1 and 2, in that order.
- R6: A seed bit of 1 drives dout_o high for PULSE_TICKS ticks (default 3) from the start of its slot. A seed bit of 0 keeps dout_o low for the whole slot.
- R7: loop_go_o is high for exactly the tick that starts at 201 µs. busy_o drops at the end of that tick, and at no other point in the run.
- R8: A start strobe that arrives while busy_o is high has no effect.
- R9: A change on seed_i after the start edge has no effect on the bits sent.
- R10: System reset (rst, active high, synchronous) returns the block to idle with all four outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz input clock |
| rst | input | 1 | Synchronous system reset, active high |
| start_i | input | 1 | Start strobe, honoured only while idle |
| seed_i | input | 4 | Seed value captured at start |
| key_rst_o | output | 1 | Reset to the partner key chip, active high |
| dout_o | output | 1 | Serial seed bit line |
| busy_o | output | 1 | Sequence in progress |
| loop_go_o | output | 1 | One-tick marker at the start of the main loop |

## Verification
The bench runs all 16 seeds and compares every output on every clock of every run against a timeline it computes itself. A design that sent the bits in plain order, or that was off by one tick on a slot edge, the reset width or the 201 µs marker, would fail on particular seeds or at particular clock counts. Midway through each run, the bench pulses start and changes seed_i. A design that restarted or sampled the seed again would then send wrong bits or show a second reset pulse. Finally, a system reset mid-run must clear every output on the next edge, and a later start must still produce a clean sequence.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int SEED_W    = 4;
  localparam int SLOT_N    = 4;
  localparam int SLOT_T0   = 33;
  localparam int SLOT_STEP = 15;
  localparam int LOOP_AT   = 201;

  // Start tick of slot s, counted from time zero.
  function automatic int slot_start(input int s);
    return SLOT_T0 + s * SLOT_STEP;
  endfunction

  // Seed bit index carried by slot s: 3 first, then 0, 1, 2.
  function automatic int slot_bit(input int s);
    return (s == 0) ? SEED_W - 1 : s - 1;
  endfunction
endpackage

// File: rtl/lss_tick_gen.sv
module lss_tick_gen #(
  parameter int CLK_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

  logic [PW-1:0] pre_q;

  assign tick = en && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else if (en)     pre_q <= pre_q + 1'b1;
  end

  generate
    if (CLK_PER_TICK > 1) begin : g_gap
      assert_tick_spacing_R1 : assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/lss_slot_decode.sv
module lss_slot_decode #(
  parameter int CW          = 8,
  parameter int PULSE_TICKS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic [CW-1:0]             tick_cnt,
  input  logic [lss_pkg::SEED_W-1:0] seed,
  output logic                      dout
);
  import lss_pkg::*;

  logic [SLOT_N-1:0] slot_on;
  logic [SLOT_N-1:0] slot_hi;

  generate
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      localparam int T_BEG = slot_start(s);
      localparam int T_END = slot_start(s) + PULSE_TICKS;
      assign slot_on[s] = run && (int'(tick_cnt) >= T_BEG) && (int'(tick_cnt) < T_END);
      assign slot_hi[s] = slot_on[s] && seed[slot_bit(s)];
    end
  endgenerate

  assign dout = |slot_hi;

  assert_one_slot_R5 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_on));
  assert_zero_quiet_R6 : assert property (@(posedge clk) disable iff (rst)
    (dout == 1'b0) || ($countones(slot_hi) == 1));
endmodule

// File: rtl/lock_seed_sender.sv
module lock_seed_sender #(
  parameter int CLK_PER_TICK  = 4,
  parameter int KEY_RST_TICKS = 2,
  parameter int PULSE_TICKS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [3:0] seed_i,
  output logic       key_rst_o,
  output logic       dout_o,
  output logic       busy_o,
  output logic       loop_go_o
);
  import lss_pkg::*;

  localparam int CW = $clog2(LOOP_AT + 1);
  localparam logic [CW-1:0] LOOP_CNT = CW'(LOOP_AT);
  localparam logic [CW-1:0] RST_CNT  = CW'(KEY_RST_TICKS);

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [SEED_W-1:0] seed_q;
  logic              tick;
  logic              accept;
  logic              at_loop;
  logic              dout_w;

  assign accept  = start_i && !busy_q;
  assign at_loop = busy_q && (cnt_q == LOOP_CNT);

  lss_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .en   (busy_q),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seed_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      seed_q <= seed_i;
    end else if (tick) begin
      if (at_loop) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  lss_slot_decode #(.CW(CW), .PULSE_TICKS(PULSE_TICKS)) slot_i (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q),
    .tick_cnt (cnt_q),
    .seed     (seed_q),
    .dout     (dout_w)
  );

  assign key_rst_o = busy_q && (cnt_q < RST_CNT);
  assign dout_o    = dout_w;
  assign busy_o    = busy_q;
  assign loop_go_o = at_loop;

  assert_start_arms_R2 : assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && key_rst_o));
  assert_rst_quiet_line_R4 : assert property (@(posedge clk) disable iff (rst)
    key_rst_o |-> !dout_o);
  assert_loop_end_R7 : assert property (@(posedge clk) disable iff (rst)
    (loop_go_o && tick) |=> !busy_o);
  assert_busy_hold_R8 : assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !(loop_go_o && tick)) |=> (busy_o && $stable(seed_q)));
  assert_reset_idle_R10 : assert property (@(posedge clk)
    rst |=> !(busy_o || key_rst_o || dout_o || loop_go_o));
endmodule

// File: tb/lock_seed_sender_tb_top.sv
module lock_seed_sender_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [3:0] seed_i;
  logic       key_rst_o, dout_o, busy_o, loop_go_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  lock_seed_sender dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .key_rst_o(key_rst_o), .dout_o(dout_o), .busy_o(busy_o), .loop_go_o(loop_go_o)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s clk %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  // Expected data line at tick us for a given seed (R5, R6).
  function automatic logic exp_dout(input int us, input logic [3:0] sd);
    int off, idx;
    if (us < 33) return 1'b0;
    off = us - 33;
    idx = off / 15;
    if (idx > 3 || (off % 15) >= 3) return 1'b0;
    return sd[(idx + 3) % 4];
  endfunction

  // Run one sequence; optionally poke start/seed midway, or reset at clock rst_at.
  task automatic run_seq(input logic [3:0] sd, input int rst_at);
    @(negedge clk);
    seed_i  = sd;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    seed_i  = ~sd;  // R9: later seed changes are ignored
    for (int k = 0; k <= 809; k++) begin
      int us;
      us = k / 4;
      if (k == rst_at) begin
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 busy", busy_o, 1'b0, k);
        chk("R10 key_rst", key_rst_o, 1'b0, k);
        chk("R10 dout", dout_o, 1'b0, k);
        chk("R10 loop_go", loop_go_o, 1'b0, k);
        rst = 1'b0;
        return;
      end
      chk((us < 1) ? "R2 busy" : "R7 busy", busy_o, (k <= 807), k);
      chk("R3 key_rst", key_rst_o, (us < 2), k);
      chk((us < 33) ? "R4 dout" : "R5/R6 dout", dout_o, exp_dout(us, sd), k);
      chk("R7 loop_go", loop_go_o, (us == 201), k);
      if (k == 121 || k == 300) begin
        start_i = 1'b1;  // R8: ignored while busy
        seed_i  = sd ^ 4'b0101;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; seed_i = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 busy reset", busy_o, 1'b0, 0);
    chk("R10 key_rst reset", key_rst_o, 1'b0, 0);
    chk("R10 dout reset", dout_o, 1'b0, 0);
    chk("R10 loop_go reset", loop_go_o, 1'b0, 0);
    rst = 1'b0;
    // R1 R5 R6: sweep all seeds against computed timeline
    for (int s = 0; s < 16; s++) run_seq(4'(s), -1);
    // R10: reset mid-run, then a clean run afterwards
    run_seq(4'hB, 250);
    run_seq(4'h6, -1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule